// File: doc/BRIEF.md
# Edge/Level Interrupt Controller with Vector

This block gathers a set of active-low external interrupt request lines and turns them into one interrupt request and one vector code for the processor. Each line first passes through a synchroniser. Each line can then be set to one of two modes. In level mode a low input counts as a request for as long as it stays low. In edge mode a falling edge is caught in a pending bit, and that bit holds until software clears it. A mask register gates the pending lines. The unmasked line with the highest priority is encoded into an 8-bit code whose two low bits are always zero, so the code can index a jump table directly.

Every line also has a wake-enable bit. When a line with its wake-enable bit set has a request, the wake output asks the system to leave low-power mode. The wake output does not depend on the interrupt mask. Software uses a small register bus. Writes are whole words. Reads can be byte, half-word or word wide, and each width returns the top of the selected register. Reading the vector register at different widths therefore gives table strides of different sizes.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the configuration and mask registers read as zero, the vector register reads 0xFC000000, and irq_o and wake_o are low.
- R2: The configuration register is at offset 0x0. Bit 31-2n is the edge select of line n and bit 30-2n is its wake-enable. Bits 15:0 read as zero and ignore writes.
- R3: In level mode (edge select 0), line n is pending while its input, seen two clocks later through the synchroniser, is low. It follows the live level, and writing 1 to its pending bit has no effect.
- R4: In edge mode, a falling edge sets the line's pending bit. The bit stays set after the input returns high and is cleared by writing 1 to bit 31-n at offset 0x8. A line held low does not set the bit again after it is cleared.
- R5: The mask register is at offset 0x4, where bit 31-n enables line n. A pending line that is masked shows in the pending register (offset 0x8, bit 31-n) but does not affect the vector or irq_o.
- R6: Line 0 has the highest priority. The vector code for line n is n*8. With nothing unmasked pending the code is 0xFC. The code sits in bits 31:24 of the vector register at offset 0xC.
- R7: size_i selects the read width. A value of 0 returns a byte, {24'b0, reg[31:24]}. A value of 1 returns a half-word, {16'b0, reg[31:16]}. A value of 2 or 3 returns the full word.
- R8: The vector register is read-only. A write to offset 0xC changes no register.
- R9: wake_o is high while any pending line has its wake-enable set, whether or not that line is masked.
- R10: irq_o is high exactly when some pending line is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_ni | input | NUM_LINES | Active-low external request lines |
| addr_i | input | 4 | Register byte address |
| we_i | input | 1 | Word write strobe |
| wdata_i | input | 32 | Write data |
| size_i | input | 2 | Read width: 0 byte, 1 half-word, 2 or 3 word |
| rdata_o | output | 32 | Read data, combinational from addr_i and size_i |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | Request to leave low-power mode |

## Verification
The bench builds the block with NUM_LINES=8 and SYNC_STAGES=2. This places configuration pairs in every used byte of the upper half-word and allows priority checks between the two ends of the range, codes 0x00 and 0x38. With a two-stage synchroniser, edge capture lands three clocks after the input changes and a level request shows after two. The edge-mode checks therefore cover the pending bit after the input releases, clearing while the line is still held low, and a line masked while pending.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned CODE_W      = 8;
  localparam int unsigned CODE_STRIDE = 8;
  localparam logic [CODE_W-1:0] IDLE_CODE = 8'hFC;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [1:0] RA_CFG  = 2'd0;
  localparam logic [1:0] RA_MASK = 2'd1;
  localparam logic [1:0] RA_PEND = 2'd2;
  localparam logic [1:0] RA_VEC  = 2'd3;
endpackage

// File: rtl/irq_line.sv
module irq_line #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_ni,
  input  logic ed_i,
  input  logic clr_i,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, edge_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], irq_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     edge_q <= 1'b0;
    else if (!ed_i)  edge_q <= 1'b0;
    else if (fall)   edge_q <= 1'b1;
    else if (clr_i)  edge_q <= 1'b0;
  end

  assign pend_o = ed_i ? edge_q : ~sync_q[SYNC_STAGES-1];

  p_edge_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ed_i && pend_o && !clr_i) |=> (pend_o || !ed_i));
  p_edge_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ed_i && clr_i && !fall) |=> !edge_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0] active_i,
  output logic [CODE_W-1:0]    code_o
);
  always_comb begin
    code_o = IDLE_CODE;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (active_i[i]) code_o = CODE_W'(i * CODE_STRIDE);
    end
  end

  always_comb begin
    if (|active_i) a_low_bits_r6: assert (code_o[1:0] == 2'b00 && code_o != IDLE_CODE);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_ni,
  input  logic [3:0]           addr_i,
  input  logic                 we_i,
  input  logic [31:0]          wdata_i,
  input  logic [1:0]           size_i,
  output logic [31:0]          rdata_o,
  output logic                 irq_o,
  output logic                 wake_o
);
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] ed_q, wm_q, mask_q, pend, clr, active;
  logic [CODE_W-1:0]    code;
  logic [31:0]          cfg_word, mask_word, pend_word, sel_word;
  logic [1:0]           reg_sel;
  logic                 unused_bits;

  assign reg_sel     = addr_i[3:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ed_q   <= '0;
      wm_q   <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (reg_sel == RA_CFG) begin
          ed_q[i] <= wdata_i[31-2*i];
          wm_q[i] <= wdata_i[30-2*i];
        end
        if (reg_sel == RA_MASK) mask_q[i] <= wdata_i[31-i];
      end
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign clr[g] = we_i && (reg_sel == RA_PEND) && wdata_i[31-g];
    irq_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .irq_ni (irq_ni[g]),
      .ed_i   (ed_q[g]),
      .clr_i  (clr[g]),
      .pend_o (pend[g])
    );
  end

  assign active = pend & mask_q;

  irq_prio_enc #(.NUM_LINES(NUM_LINES)) u_enc (
    .active_i (active),
    .code_o   (code)
  );

  assign irq_o  = |active;
  assign wake_o = |(pend & wm_q);

  always_comb begin
    cfg_word  = '0;
    mask_word = '0;
    pend_word = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      cfg_word[31-2*i] = ed_q[i];
      cfg_word[30-2*i] = wm_q[i];
      mask_word[31-i]  = mask_q[i];
      pend_word[31-i]  = pend[i];
    end
  end

  always_comb begin
    unique case (reg_sel)
      RA_CFG:  sel_word = cfg_word;
      RA_MASK: sel_word = mask_word;
      RA_PEND: sel_word = pend_word;
      default: sel_word = {code, 24'h0};
    endcase
    if (size_i == SZ_BYTE)      rdata_o = {24'h0, sel_word[31:24]};
    else if (size_i == SZ_HALF) rdata_o = {16'h0, sel_word[31:16]};
    else                        rdata_o = sel_word;
  end

  p_irq_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (code != IDLE_CODE));
  p_winner_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q[code[IDX_W+2:3]] && pend[code[IDX_W+2:3]]));
  p_masked_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend & wm_q & ~mask_q)) |-> wake_o);
  p_cfg_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel == RA_CFG && size_i[1]) |-> rdata_o[15:0] == 16'h0);
  p_vec_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && reg_sel == RA_VEC) |=> ($stable(ed_q) && $stable(wm_q) && $stable(mask_q)));
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_n = '1;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] rdata;
  logic        irq, wake;

  always #5 clk = ~clk;

  irq_vec_ctrl #(.NUM_LINES(N), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .size_i(size), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 irq_o, 2 wake_o
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor / scoreboard
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {31'h0, irq};
        default: act = {31'h0, wake};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %08h expected %08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0;
  endtask

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    tick(1);
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] sz, logic [31:0] exp, string tag);
    addr = a; size = sz;
    push(0, exp, tag);
  endtask

  function automatic logic [31:0] vec(int line);
    return (line < 0) ? 32'hFC00_0000 : (32'(line * 8) << 24);
  endfunction

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd(4'h0, 2'd2, 32'h0, "R1 cfg");
    rd(4'h4, 2'd2, 32'h0, "R1 mask");
    rd(4'hC, 2'd2, vec(-1), "R1 vector");
    push(1, 0, "R1 irq_o");
    push(2, 0, "R1 wake_o");
    // R2 layout, low half unused
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 2'd2, 32'hFFFF_0000, "R2 cfg low half");
    wr(4'h0, 32'h0);
    rd(4'h0, 2'd3, 32'h0, "R2 cfg cleared");
    // R5 mask
    wr(4'h4, 32'hFF00_0000);
    rd(4'h4, 2'd2, 32'hFF00_0000, "R5 mask readback");
    // R3 level mode, line 3
    irq_n[3] = 1'b0; tick(4);
    rd(4'hC, 2'd2, vec(3), "R3 level vector");
    rd(4'hC, 2'd0, 32'h18, "R7 byte read");
    rd(4'hC, 2'd1, 32'h1800, "R7 half read");
    push(1, 1, "R10 irq_o set");
    rd(4'h8, 2'd2, 32'h1000_0000, "R3 pending bit");
    wr(4'h8, 32'hFF00_0000);
    rd(4'hC, 2'd2, vec(3), "R3 clear ignored");
    irq_n[1] = 1'b0; tick(4);
    rd(4'hC, 2'd2, vec(1), "R6 line1 over line3");
    irq_n[1] = 1'b1; irq_n[3] = 1'b1; tick(4);
    rd(4'hC, 2'd2, vec(-1), "R3 level released");
    push(1, 0, "R10 irq_o clear");
    // R6 priority ends
    irq_n[0] = 1'b0; irq_n[7] = 1'b0; tick(4);
    rd(4'hC, 2'd2, vec(0), "R6 line0 wins");
    wr(4'h4, 32'h7F00_0000);
    rd(4'hC, 2'd2, vec(7), "R6 line7 code");
    rd(4'h8, 2'd2, 32'h8100_0000, "R5 masked still pending");
    irq_n[0] = 1'b1; irq_n[7] = 1'b1; wr(4'h4, 32'hFF00_0000); tick(4);
    // R4 edge mode, line 5
    wr(4'h0, 32'h0020_0000);
    irq_n[5] = 1'b0; tick(2);
    irq_n[5] = 1'b1; tick(4);
    rd(4'hC, 2'd2, vec(5), "R4 edge latched");
    rd(4'h8, 2'd2, 32'h0400_0000, "R4 pending bit");
    wr(4'h4, 32'hFB00_0000);
    rd(4'hC, 2'd2, vec(-1), "R5 masked vector");
    push(1, 0, "R5 masked irq_o");
    rd(4'h8, 2'd2, 32'h0400_0000, "R5 masked pending");
    wr(4'h4, 32'hFF00_0000);
    rd(4'hC, 2'd2, vec(5), "R5 unmasked vector");
    wr(4'h8, 32'h0400_0000);
    rd(4'hC, 2'd2, vec(-1), "R4 cleared");
    push(1, 0, "R4 irq_o after clear");
    // R4 held low: no retrigger
    irq_n[5] = 1'b0; tick(4);
    rd(4'hC, 2'd2, vec(5), "R4 held low edge");
    wr(4'h8, 32'h0400_0000);
    tick(3);
    rd(4'hC, 2'd2, vec(-1), "R4 no retrigger");
    irq_n[5] = 1'b1; tick(4);
    // R9 wake, independent of mask
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h0400_0000);
    irq_n[2] = 1'b0; tick(4);
    push(2, 1, "R9 wake masked line");
    push(1, 0, "R10 masked no irq");
    wr(4'h0, 32'h0);
    push(2, 0, "R9 wake disabled");
    irq_n[2] = 1'b1; tick(4);
    // R8 vector read-only
    wr(4'h0, 32'hA000_0000);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, 2'd2, 32'hA000_0000, "R8 cfg unchanged");
    rd(4'h4, 2'd2, 32'h0, "R8 mask unchanged");
    rd(4'hC, 2'd2, vec(-1), "R8 vector idle");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule